// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level page table held in memory. A request starts with a one-cycle `start` pulse carrying the linear address, the access kind (read or write), the requester's privilege (user or supervisor), the table root and a paging-enable bit. The walker fetches the directory entry, then the table entry, through a single request/acknowledge memory port. It writes back entries whose accessed or dirty flags must change and checks presence and access rights. It ends the request with a one-cycle `done` pulse, together with either the physical address or a fault flag.

When paging is off, the linear address passes straight through and memory is not touched. When a walk faults, the faulting linear address is held on a dedicated output until the next fault. The walker has no translation cache. Every walk goes to memory.

Top module: `pgw_top`

## Requirements
- R1: After a synchronous reset, `done`, `fault`, `busy` and `mem_req` are 0 and `fault_lin` is 0.
- R2: A `start` with `pg_en`=0 raises `done` at the next clock edge with `fault`=0 and `phys_addr` equal to the linear address, and issues no memory access.
- R3: The directory entry is read at `{root[31:12], 12'b0} + lin[31:22]*4`, and the table entry at `{dir_entry[31:12], 12'b0} + lin[21:12]*4`. The low 12 bits of the root and of the directory entry are ignored as address bits.
- R4: On a successful walk, `phys_addr` is `{table_entry[31:12], lin[11:0]}`.
- R5: Entry flags are bit 0 present, bit 1 writable, bit 2 supervisor-only, bit 5 accessed and bit 6 dirty. A present directory or table entry whose accessed bit is 0 is written back to the same address with bit 5 set and every other bit unchanged. An entry whose accessed bit is already 1 is not written.
- R6: A write access that passes all checks sets bit 6 of the table entry when that bit is clear, in the same write-back as the accessed bit. Bit 6 of a directory entry is never changed.
- R7: A directory or table entry with bit 0 clear ends the walk with `fault`=1 and no further memory access. A faulting table entry is not written.
- R8: A page is supervisor-only if bit 2 is 1 in either entry, and read-only if bit 1 is 0 in either entry. A user access to a supervisor-only page faults. A user write to a read-only page faults. Supervisor accesses never fail the rights check. A rights fault leaves the table entry unwritten.
- R9: `fault_lin` takes the linear address of a faulting walk in the cycle `fault` is raised, and otherwise keeps its value.
- R10: Once `mem_req` is raised, it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until `mem_ack` is seen. Any acknowledge latency is accepted.
- R11: `busy` is 1 from the edge that accepts `start` until the edge that raises `done`. A `start` while busy is ignored. `done` is a one-cycle pulse, and `fault` is only high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted when not busy |
| lin_addr | input | 32 | Linear address to translate |
| acc_write | input | 1 | 1 for a write access |
| acc_user | input | 1 | 1 for a user-level access |
| root | input | 32 | Directory base; bits 31:12 used |
| pg_en | input | 1 | Paging enable |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Page fault, valid with done |
| phys_addr | output | 32 | Translated address, valid with done and no fault |
| fault_lin | output | 32 | Linear address of the latest fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write-back |
| mem_addr | output | 32 | Entry byte address |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read data |

## Verification
Each result arrives a fixed number of edges after the edge that accepts `start`, given a memory that acknowledges one edge after a request. The bypass result arrives after 1 edge. A walk needing no write-back arrives after 5 edges. Each write-back adds 2 edges, and a directory fault arrives after 3. The bench counts edges from the accepting edge and samples outputs at the following falling edge. It compares the count with the expected latency, and then checks the result, the fault address and the entry contents in memory. One run uses a slower memory to show that results do not depend on acknowledge latency; that run does not check timing.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int FLAG_PRESENT  = 0;
  localparam int FLAG_WRITABLE = 1;
  localparam int FLAG_SUPER    = 2;
  localparam int FLAG_ACCESSED = 5;
  localparam int FLAG_DIRTY    = 6;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_RD_DIR,
    WS_WR_DIR,
    WS_RD_TBL,
    WS_WR_TBL
  } walk_state_t;
endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] base_word,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int ENT_SHIFT = 2;
  localparam int PAD_W     = ADDR_W - IDX_W - ENT_SHIFT;

  logic [ADDR_W-1:0] aligned_base;
  logic [ADDR_W-1:0] scaled_idx;

  assign aligned_base = {base_word[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign scaled_idx   = {{PAD_W{1'b0}}, index, {ENT_SHIFT{1'b0}}};
  assign entry_addr   = aligned_base | scaled_idx;
endmodule

// File: rtl/pgw_rights.sv
module pgw_rights #(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] dir_ent,
  input  logic [ENT_W-1:0] tbl_ent,
  input  logic             is_user,
  input  logic             is_write,
  output logic             allow
);
  import pgw_pkg::*;

  logic super_only;
  logic read_only;

  always_comb begin
    super_only = dir_ent[FLAG_SUPER] | tbl_ent[FLAG_SUPER];
    read_only  = ~(dir_ent[FLAG_WRITABLE] & tbl_ent[FLAG_WRITABLE]);
    allow      = 1'b1;
    if (is_user && super_only) allow = 1'b0;
    if (is_user && is_write && read_only) allow = 1'b0;
  end
endmodule

// File: rtl/pgw_flag_upd.sv
module pgw_flag_upd #(
  parameter int ENT_W = 32,
  parameter bit LEAF  = 1'b0
) (
  input  logic [ENT_W-1:0] cur_ent,
  input  logic             is_write,
  output logic [ENT_W-1:0] new_ent,
  output logic             needs_wb
);
  import pgw_pkg::*;

  logic [ENT_W-1:0] set_mask;

  generate
    if (LEAF) begin : g_leaf
      always_comb begin
        set_mask = '0;
        set_mask[FLAG_ACCESSED] = 1'b1;
        set_mask[FLAG_DIRTY]    = is_write;
      end
    end else begin : g_dir
      always_comb begin
        set_mask = '0;
        set_mask[FLAG_ACCESSED] = 1'b1;
      end
    end
  endgenerate

  assign new_ent  = cur_ent | set_mask;
  assign needs_wb = (new_ent != cur_ent);
endmodule

// File: rtl/pgw_top.sv
module pgw_top #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] lin_addr,
  input  logic              acc_write,
  input  logic              acc_user,
  input  logic [ADDR_W-1:0] root,
  input  logic              pg_en,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [ADDR_W-1:0] fault_lin,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata
);
  import pgw_pkg::*;

  localparam int TBL_LSB = OFF_W;
  localparam int DIR_LSB = OFF_W + IDX_W;

  walk_state_t       st;
  logic [ADDR_W-1:0] lin_q;
  logic              wr_q;
  logic              usr_q;
  logic [ADDR_W-1:0] dir_q;
  logic [ADDR_W-1:0] tbl_q;

  logic [ADDR_W-1:0] dir_addr;
  logic [ADDR_W-1:0] tbl_addr;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] dir_new;
  logic              dir_wb;
  logic [ADDR_W-1:0] tbl_new;
  logic              tbl_wb;
  logic              rights_ok;

  assign tbl_base = (st == WS_RD_DIR) ? mem_rdata : dir_q;

  pgw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dir_addr (
    .base_word  (root),
    .index      (lin_addr[DIR_LSB +: IDX_W]),
    .entry_addr (dir_addr)
  );

  pgw_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tbl_addr (
    .base_word  (tbl_base),
    .index      (lin_q[TBL_LSB +: IDX_W]),
    .entry_addr (tbl_addr)
  );

  pgw_flag_upd #(.ENT_W(ADDR_W), .LEAF(1'b0)) u_dir_upd (
    .cur_ent  (mem_rdata),
    .is_write (wr_q),
    .new_ent  (dir_new),
    .needs_wb (dir_wb)
  );

  pgw_flag_upd #(.ENT_W(ADDR_W), .LEAF(1'b1)) u_tbl_upd (
    .cur_ent  (mem_rdata),
    .is_write (wr_q),
    .new_ent  (tbl_new),
    .needs_wb (tbl_wb)
  );

  pgw_rights #(.ENT_W(ADDR_W)) u_rights (
    .dir_ent  (dir_q),
    .tbl_ent  (mem_rdata),
    .is_user  (usr_q),
    .is_write (wr_q),
    .allow    (rights_ok)
  );

  assign busy = (st != WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= WS_IDLE;
      lin_q     <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      dir_q     <= '0;
      tbl_q     <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      phys_addr <= '0;
      fault_lin <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        WS_IDLE: begin
          if (start) begin
            lin_q <= lin_addr;
            wr_q  <= acc_write;
            usr_q <= acc_user;
            if (!pg_en) begin
              done      <= 1'b1;
              phys_addr <= lin_addr;
            end else begin
              st       <= WS_RD_DIR;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= dir_addr;
            end
          end
        end
        WS_RD_DIR: begin
          if (mem_ack) begin
            dir_q <= mem_rdata;
            if (!mem_rdata[FLAG_PRESENT]) begin
              st        <= WS_IDLE;
              mem_req   <= 1'b0;
              mem_we    <= 1'b0;
              done      <= 1'b1;
              fault     <= 1'b1;
              fault_lin <= lin_q;
            end else if (dir_wb) begin
              st        <= WS_WR_DIR;
              dir_q     <= dir_new;
              mem_we    <= 1'b1;
              mem_wdata <= dir_new;
            end else begin
              st       <= WS_RD_TBL;
              mem_we   <= 1'b0;
              mem_addr <= tbl_addr;
            end
          end
        end
        WS_WR_DIR: begin
          if (mem_ack) begin
            st       <= WS_RD_TBL;
            mem_we   <= 1'b0;
            mem_addr <= tbl_addr;
          end
        end
        WS_RD_TBL: begin
          if (mem_ack) begin
            tbl_q <= mem_rdata;
            if (!mem_rdata[FLAG_PRESENT] || !rights_ok) begin
              st        <= WS_IDLE;
              mem_req   <= 1'b0;
              mem_we    <= 1'b0;
              done      <= 1'b1;
              fault     <= 1'b1;
              fault_lin <= lin_q;
            end else if (tbl_wb) begin
              st        <= WS_WR_TBL;
              tbl_q     <= tbl_new;
              mem_we    <= 1'b1;
              mem_wdata <= tbl_new;
            end else begin
              st        <= WS_IDLE;
              mem_req   <= 1'b0;
              done      <= 1'b1;
              phys_addr <= {mem_rdata[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
            end
          end
        end
        WS_WR_TBL: begin
          if (mem_ack) begin
            st        <= WS_IDLE;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            done      <= 1'b1;
            phys_addr <= {tbl_q[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
          end
        end
        default: begin
          st      <= WS_IDLE;
          mem_req <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] lin_addr,
  input logic              pg_en,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] phys_addr,
  input logic [ADDR_W-1:0] fault_lin,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] mem_wdata,
  input logic              mem_ack
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    fault |-> done); // R11

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R11

  AST_FAULT_LIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(fault_lin) || fault)); // R9

  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !pg_en |=> done && !fault && (phys_addr == $past(lin_addr))); // R2

  AST_WB_SETS_A: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[5]); // R5
endmodule

bind pgw_top pgw_chk #(.ADDR_W(ADDR_W)) u_pgw_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .lin_addr  (lin_addr),
  .pg_en     (pg_en),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .phys_addr (phys_addr),
  .fault_lin (fault_lin),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/tb_pgw_top.sv
`timescale 1ns/1ps
module tb_pgw_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] lin_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_user = 1'b0;
  logic [31:0] root = 32'h0010_0ABC;
  logic        pg_en = 1'b1;
  logic        busy, done, fault, mem_req, mem_we;
  logic [31:0] phys_addr, fault_lin, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  pgw_top dut (
    .clk(clk), .rst(rst), .start(start), .lin_addr(lin_addr),
    .acc_write(acc_write), .acc_user(acc_user), .root(root), .pg_en(pg_en),
    .busy(busy), .done(done), .fault(fault), .phys_addr(phys_addr),
    .fault_lin(fault_lin), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model
  logic [31:0] mem [logic [31:0]];
  int ack_dly = 0;
  int dly_cnt = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (dly_cnt < ack_dly) begin
        dly_cnt = dly_cnt + 1;
      end else begin
        dly_cnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt = wr_cnt + 1;
        end else begin
          mem_rdata <= mrd(mem_addr);
          rd_cnt = rd_cnt + 1;
        end
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] lin;
    logic        wr;
    logic        usr;
    logic [31:0] pde;
    logic [31:0] pte;
    logic        flt;
    logic [31:0] pde_after;
    logic [31:0] pte_after;
    logic [7:0]  cyc;
    logic [1:0]  nwr;
    logic [31:0] phys;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h0040_3123, 1'b0, 1'b0, 32'h0020_0027, 32'h0ABC_D027, 1'b0, 32'h0020_0027, 32'h0ABC_D027, 8'd5, 2'd0, 32'h0ABC_D123},
    '{32'h0080_5456, 1'b1, 1'b1, 32'h0020_1003, 32'h1234_5003, 1'b0, 32'h0020_1023, 32'h1234_5063, 8'd9, 2'd2, 32'h1234_5456},
    '{32'h00C0_7000, 1'b0, 1'b1, 32'h0020_2E25, 32'h3333_3001, 1'b1, 32'h0020_2E25, 32'h3333_3001, 8'd5, 2'd0, 32'h0},
    '{32'h0100_1ABC, 1'b1, 1'b1, 32'h0020_3063, 32'h4444_4021, 1'b1, 32'h0020_3063, 32'h4444_4021, 8'd5, 2'd0, 32'h0},
    '{32'h0140_2010, 1'b1, 1'b0, 32'h0020_4001, 32'h5555_5025, 1'b0, 32'h0020_4021, 32'h5555_5065, 8'd9, 2'd2, 32'h5555_5010},
    '{32'h0180_0FFF, 1'b0, 1'b0, 32'h0020_5026, 32'h0000_0000, 1'b1, 32'h0020_5026, 32'h0000_0000, 8'd3, 2'd0, 32'h0},
    '{32'h01C0_3004, 1'b0, 1'b0, 32'h0020_6007, 32'h6666_6066, 1'b1, 32'h0020_6027, 32'h6666_6066, 8'd7, 2'd1, 32'h0},
    '{32'h0200_4A5A, 1'b0, 1'b1, 32'h0020_7023, 32'h7777_7E01, 1'b0, 32'h0020_7023, 32'h7777_7E21, 8'd7, 2'd1, 32'h7777_7A5A}
  };

  int          n_cyc;
  int          n_done;
  logic        r_fault;
  logic [31:0] r_phys;
  logic [31:0] r_flin;

  // inj_at > 0 drives a second start that many cycles after the first
  task automatic walk(input logic [31:0] la, input logic w, input logic u, input logic en,
                      input int inj_at, input logic [31:0] inj_lin);
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    lin_addr = la; acc_write = w; acc_user = u; pg_en = en; start = 1'b1;
    n_cyc = 0; n_done = 0;
    while (n_cyc < 300) begin
      @(posedge clk);
      n_cyc++;
      @(negedge clk);
      start = 1'b0;
      if (inj_at != 0 && n_cyc == inj_at) begin
        lin_addr = inj_lin; pg_en = 1'b0; start = 1'b1;
      end
      if (done) begin
        n_done++;
        r_fault = fault; r_phys = phys_addr; r_flin = fault_lin;
        break;
      end
    end
    start = 1'b0; pg_en = 1'b1;
    if (n_done == 0) begin
      errors++; checks++;
      $display("FAIL R11: walk hung, actual no done expected done");
    end
  endtask

  function automatic logic [31:0] pde_loc(input logic [31:0] la);
    return 32'h0010_0000 + {20'd0, la[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] pte_loc(input logic [31:0] pde, input logic [31:0] la);
    return {pde[31:12], 12'h000} + {20'd0, la[21:12], 2'b00};
  endfunction

  logic [31:0] exp_flin = 32'h0;

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 fault", {31'd0, fault}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 fault_lin", fault_lin, 32'd0);
    rst = 1'b0;

    // R2 bypass
    walk(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 0, 32'h0);
    chk("R2 latency", n_cyc, 32'd1);
    chk("R2 phys", r_phys, 32'hDEAD_BEEF);
    chk("R2 fault", {31'd0, r_fault}, 32'd0);
    chk("R2 no access", rd_cnt + wr_cnt, 32'd0);

    // table-driven walks: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] pl, tl;
      pl = pde_loc(VEC[i].lin);
      tl = pte_loc(VEC[i].pde, VEC[i].lin);
      mem[pl] = VEC[i].pde;
      mem[tl] = VEC[i].pte;
      walk(VEC[i].lin, VEC[i].wr, VEC[i].usr, 1'b1, 0, 32'h0);
      if (VEC[i].flt) exp_flin = VEC[i].lin;
      chk($sformatf("R7 R8 fault v%0d", i), {31'd0, r_fault}, {31'd0, VEC[i].flt});
      chk($sformatf("R3 latency v%0d", i), n_cyc, {24'd0, VEC[i].cyc});
      chk($sformatf("R5 write count v%0d", i), wr_cnt, {30'd0, VEC[i].nwr});
      chk($sformatf("R5 R6 dir entry v%0d", i), mrd(pl), VEC[i].pde_after);
      chk($sformatf("R5 R6 tbl entry v%0d", i), mrd(tl), VEC[i].pte_after);
      chk($sformatf("R9 fault_lin v%0d", i), r_flin, exp_flin);
      if (!VEC[i].flt)
        chk($sformatf("R4 phys v%0d", i), r_phys, VEC[i].phys);
    end

    // R11: start while busy ignored (entry 0 has flags set, no write-back)
    walk(VEC[0].lin, 1'b0, 1'b0, 1'b1, 2, 32'h0BAD_0000);
    chk("R11 first result kept", r_phys, VEC[0].phys);
    chk("R11 latency unchanged", n_cyc, 32'd5);
    begin
      int extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R11 no extra done", extra, 32'd0);
    end

    // R10: slow memory
    ack_dly = 3;
    walk(VEC[1].lin, 1'b1, 1'b1, 1'b1, 0, 32'h0);
    chk("R10 slow phys", r_phys, VEC[1].phys);
    chk("R10 slow fault", {31'd0, r_fault}, 32'd0);
    chk("R10 slow reads", rd_cnt, 32'd2);
    ack_dly = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule